// File: doc/BRIEF.md
# Counted IO Slot Interrupt Aggregator

This block collects interrupt requests from the devices attached to one CPU's IO slots and turns them into requests for a downstream interrupt pending controller. Each slot keeps a saturating count of how many of its requests are still outstanding. Each slot also has a programmable entry that gives the interrupt code to use for that slot. Devices send single-cycle raise or clear events tagged with a slot index. The block only contacts the controller when a slot's count moves between zero and nonzero. The controller therefore sees one set-code request for the first outstanding request and one clear-code request when the last one is withdrawn.

A clear that finds the slot already at zero is treated as a protocol slip by the device side. The count stays at zero, nothing is sent downstream, and a one-cycle underflow pulse is given instead. The mapping table is written through a simple write strobe. A slot's code can be changed while the block runs, and events then pick up the new code.

Top module: `slot_irq_agg`

## Requirements
- R1: After reset every slot count is zero and every mapping entry holds code 0, and `req_valid` and `underflow` are low; a first raise on any slot then requests code 0.
- R2: A raise event (`ev_valid`=1, `ev_raise`=1) on a slot whose count is zero gives, in the cycle after the event edge, `req_valid`=1, `req_set`=1 and `req_code` equal to that slot's mapped code.
- R3: A raise event on a slot with a nonzero count increments the count and gives no request.
- R4: A clear event (`ev_valid`=1, `ev_raise`=0) on a slot whose count is one gives, in the cycle after the event edge, `req_valid`=1, `req_set`=0 and `req_code` equal to the mapped code.
- R5: A clear event on a slot with a count above one decrements the count and gives no request.
- R6: A clear event on a slot whose count is zero gives no request, leaves the count at zero (the next raise requests again), and pulses `underflow` for one cycle.
- R7: A count saturates at 2^CNT_W-1 (255 by default): further raises hold it there, and exactly that many clears are then needed to produce the clear request.
- R8: `map_we`=1 stores `map_code` into the entry of `map_slot`; an event in the same cycle on that slot uses the old code, and later events use the new code.
- R9: Slot counts are independent: events on one slot never change another slot's count.
- R10: `req_valid` and `underflow` are single-cycle pulses, and at most one request is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Device event strobe |
| ev_raise | input | 1 | 1 = raise, 0 = clear |
| ev_slot | input | SLOT_W (3) | Slot index of the event |
| map_we | input | 1 | Mapping entry write strobe |
| map_slot | input | SLOT_W (3) | Slot whose mapping is written |
| map_code | input | CODE_W (6) | Code to store |
| req_valid | output | 1 | Downstream request strobe |
| req_set | output | 1 | 1 = set code, 0 = clear code |
| req_code | output | CODE_W (6) | Interrupt code of the request |
| underflow | output | 1 | Clear arrived at a zero count |

## Verification
A count that is off by one shows up at the ports only at the next zero crossing. The bench therefore drives each slot through full raise-and-clear sequences and checks exactly which event produces the request. A count that wrapped instead of staying at zero is exposed by the very next raise, which then fails to request. A count that wrapped at the top is exposed when the clear request comes too early during a long drain. A wrong mapping entry appears in `req_code` one cycle after the next crossing on that slot.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
   typedef enum logic {
      KIND_CLEAR = 1'b0,
      KIND_SET   = 1'b1
   } req_kind_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic rise_ev,
   output logic fall_ev,
   output logic under_ev
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;
   logic             at_one;
   logic             at_full;

   assign at_zero = (cnt_q == '0);
   assign at_one  = (cnt_q == CNT_W'(1));
   assign at_full = &cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !at_full) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (dec && !at_zero) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign rise_ev  = inc & at_zero;
   assign fall_ev  = dec & at_one;
   assign under_ev = dec & at_zero;
endmodule

// File: rtl/slot_map_table.sv
module slot_map_table #(
   parameter int NUM_SLOTS = 8,
   parameter int CODE_W    = 6,
   parameter int SLOT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [CODE_W-1:0] rd_code
);
   logic [CODE_W-1:0] entry_q [NUM_SLOTS];

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entry_q[i] <= '0;
         end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
            entry_q[i] <= wr_code;
         end
      end
   end

   always_comb begin
      rd_code = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (rd_slot == SLOT_W'(i)) rd_code = entry_q[i];
      end
   end
endmodule

// File: rtl/req_encoder.sv
module req_encoder
   import slot_irq_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_rise,
   input  logic              any_fall,
   input  logic              any_under,
   input  logic [CODE_W-1:0] code_in,
   output logic              req_valid,
   output logic              req_set,
   output logic [CODE_W-1:0] req_code,
   output logic              underflow
);
   logic              nxt_valid;
   req_kind_e         nxt_kind;
   logic [CODE_W-1:0] nxt_code;

   always_comb begin
      nxt_valid = any_rise | any_fall;
      nxt_kind  = any_rise ? KIND_SET : KIND_CLEAR;
      nxt_code  = nxt_valid ? code_in : '0;
   end

   if (OUT_REG) begin : g_reg
      logic              valid_q;
      logic              set_q;
      logic [CODE_W-1:0] code_q;
      logic              under_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            set_q   <= 1'b0;
            code_q  <= '0;
            under_q <= 1'b0;
         end else begin
            valid_q <= nxt_valid;
            set_q   <= nxt_valid & (nxt_kind == KIND_SET);
            code_q  <= nxt_code;
            under_q <= any_under;
         end
      end

      assign req_valid = valid_q;
      assign req_set   = set_q;
      assign req_code  = code_q;
      assign underflow = under_q;
   end else begin : g_comb
      assign req_valid = nxt_valid;
      assign req_set   = nxt_valid & (nxt_kind == KIND_SET);
      assign req_code  = nxt_code;
      assign underflow = any_under;
   end
endmodule

// File: rtl/slot_irq_agg.sv
module slot_irq_agg
   import slot_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int CNT_W     = 8,
   parameter int CODE_W    = 6,
   parameter bit OUT_REG   = 1'b1,
   localparam int SLOT_W   = idx_width(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic              ev_raise,
   input  logic [SLOT_W-1:0] ev_slot,
   input  logic              map_we,
   input  logic [SLOT_W-1:0] map_slot,
   input  logic [CODE_W-1:0] map_code,
   output logic              req_valid,
   output logic              req_set,
   output logic [CODE_W-1:0] req_code,
   output logic              underflow
);
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("slot_irq_agg: NUM_SLOTS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("slot_irq_agg: CNT_W must be at least 1");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("slot_irq_agg: CODE_W must be at least 1");
   end

   logic [NUM_SLOTS-1:0] rise_v;
   logic [NUM_SLOTS-1:0] fall_v;
   logic [NUM_SLOTS-1:0] under_v;
   logic [CODE_W-1:0]    slot_code;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic hit;
      assign hit = ev_valid && (ev_slot == SLOT_W'(i));

      slot_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (hit & ev_raise),
         .dec      (hit & ~ev_raise),
         .rise_ev  (rise_v[i]),
         .fall_ev  (fall_v[i]),
         .under_ev (under_v[i])
      );
   end

   slot_map_table #(
      .NUM_SLOTS (NUM_SLOTS),
      .CODE_W    (CODE_W),
      .SLOT_W    (SLOT_W)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (map_we),
      .wr_slot (map_slot),
      .wr_code (map_code),
      .rd_slot (ev_slot),
      .rd_code (slot_code)
   );

   req_encoder #(
      .CODE_W  (CODE_W),
      .OUT_REG (OUT_REG)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_rise  (|rise_v),
      .any_fall  (|fall_v),
      .any_under (|under_v),
      .code_in   (slot_code),
      .req_valid (req_valid),
      .req_set   (req_set),
      .req_code  (req_code),
      .underflow (underflow)
   );
endmodule

// File: rtl/slot_irq_agg_chk.sv
module slot_irq_agg_chk #(
   parameter int SLOT_W  = 3,
   parameter int CODE_W  = 6,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic              ev_raise,
   input logic [SLOT_W-1:0] ev_slot,
   input logic              req_valid,
   input logic              req_set,
   input logic [CODE_W-1:0] req_code,
   input logic              underflow
);
   // R6, R10: an underflow never coincides with a request
   a_r6_under_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> !req_valid);

   if (OUT_REG) begin : g_seq
      // R2: a set request follows a raise event
      a_r2_set_from_raise: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_set) |-> $past(ev_valid && ev_raise));
      // R4: a clear request follows a clear event
      a_r4_clr_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_set) |-> $past(ev_valid && !ev_raise));
      // R6: underflow follows a clear event
      a_r6_under_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
         underflow |-> $past(ev_valid && !ev_raise));
      // R10: no event, no output pulse
      a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(ev_valid) |-> (!req_valid && !underflow));
   end
endmodule

bind slot_irq_agg slot_irq_agg_chk #(
   .SLOT_W  (SLOT_W),
   .CODE_W  (CODE_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ev_raise  (ev_raise),
   .ev_slot   (ev_slot),
   .req_valid (req_valid),
   .req_set   (req_set),
   .req_code  (req_code),
   .underflow (underflow)
);

// File: tb/tb_slot_irq_agg.sv
`timescale 1ns/1ps
module tb_slot_irq_agg;
   localparam int SW = 3;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_valid = 1'b0;
   logic          ev_raise = 1'b0;
   logic [SW-1:0] ev_slot = '0;
   logic          map_we = 1'b0;
   logic [SW-1:0] map_slot = '0;
   logic [CW-1:0] map_code = '0;
   logic          req_valid;
   logic          req_set;
   logic [CW-1:0] req_code;
   logic          underflow;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   slot_irq_agg dut (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_raise(ev_raise), .ev_slot(ev_slot),
      .map_we(map_we), .map_slot(map_slot), .map_code(map_code),
      .req_valid(req_valid), .req_set(req_set), .req_code(req_code),
      .underflow(underflow)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle of inputs, then sample the registered outputs
   task automatic step(input bit v, input bit r, input int s,
                       input bit we, input int ms, input int mc);
      @(negedge clk);
      ev_valid = v; ev_raise = r; ev_slot = SW'(s);
      map_we = we; map_slot = SW'(ms); map_code = CW'(mc);
      @(negedge clk);
      ev_valid = 1'b0; map_we = 1'b0;
   endtask

   task automatic ev(input bit r, input int s);
      step(1'b1, r, s, 1'b0, 0, 0);
   endtask

   task automatic map_wr(input int s, input int c);
      step(1'b0, 1'b0, 0, 1'b1, s, c);
   endtask

   task automatic expect_req(input string req, input bit set, input int code);
      chk({req, " valid"}, int'(req_valid), 1);
      chk({req, " set"}, int'(req_set), int'(set));
      chk({req, " code"}, int'(req_code), code);
      chk({req, " no underflow"}, int'(underflow), 0);
   endtask

   task automatic expect_none(input string req);
      chk({req, " no request"}, int'(req_valid), 0);
      chk({req, " no underflow"}, int'(underflow), 0);
   endtask

   task automatic t_reset();
      chk("R1 valid low", int'(req_valid), 0);
      chk("R1 underflow low", int'(underflow), 0);
      ev(1'b1, 5);
      expect_req("R1 default code", 1'b1, 0);
      ev(1'b0, 5);
      expect_req("R1 default clear", 1'b0, 0);
   endtask

   task automatic t_basic();
      map_wr(2, 17);
      ev(1'b1, 2);
      expect_req("R2 first raise", 1'b1, 17);
      @(negedge clk);
      chk("R10 pulse one cycle", int'(req_valid), 0);
      ev(1'b1, 2);
      expect_none("R3 second raise");
      ev(1'b1, 2);
      expect_none("R3 third raise");
      ev(1'b0, 2);
      expect_none("R5 clear 3->2");
      ev(1'b0, 2);
      expect_none("R5 clear 2->1");
      ev(1'b0, 2);
      expect_req("R4 last clear", 1'b0, 17);
   endtask

   task automatic t_underflow();
      map_wr(6, 42);
      ev(1'b0, 6);
      chk("R6 underflow pulse", int'(underflow), 1);
      chk("R6 no request", int'(req_valid), 0);
      @(negedge clk);
      chk("R6 underflow one cycle", int'(underflow), 0);
      ev(1'b1, 6);
      expect_req("R6 count stayed zero", 1'b1, 42);
      ev(1'b0, 6);
      expect_req("R6 back to zero", 1'b0, 42);
   endtask

   task automatic t_saturate();
      int extra;
      map_wr(3, 63);
      ev(1'b1, 3);
      expect_req("R7 first raise", 1'b1, 63);
      extra = 0;
      for (int k = 0; k < 299; k++) begin
         ev(1'b1, 3);
         if (req_valid) extra++;
      end
      chk("R7 no request while saturating", extra, 0);
      extra = 0;
      for (int k = 0; k < 254; k++) begin
         ev(1'b0, 3);
         if (req_valid || underflow) extra++;
      end
      chk("R7 no early clear", extra, 0);
      ev(1'b0, 3);
      expect_req("R7 clear at 255th", 1'b0, 63);
   endtask

   task automatic t_map_same_cycle();
      map_wr(1, 9);
      step(1'b1, 1'b1, 1, 1'b1, 1, 33);
      expect_req("R8 same cycle old code", 1'b1, 9);
      ev(1'b0, 1);
      expect_req("R8 later new code", 1'b0, 33);
   endtask

   task automatic t_independent();
      map_wr(0, 4);
      map_wr(7, 11);
      ev(1'b1, 0);
      expect_req("R9 slot0 raise", 1'b1, 4);
      ev(1'b1, 7);
      expect_req("R9 slot7 raise", 1'b1, 11);
      ev(1'b0, 7);
      expect_req("R9 slot7 clear", 1'b0, 11);
      ev(1'b0, 0);
      expect_req("R9 slot0 clear", 1'b0, 4);
      ev(1'b0, 0);
      chk("R9 slot0 underflow", int'(underflow), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_underflow();
      t_saturate();
      t_map_same_cycle();
      t_independent();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule